// File: doc/BRIEF.md
# Segmented TLP Transmit Protocol Checker

This block is a passive monitor that sits beside a segmented transmit streaming bus feeding packets toward a transaction-layer core. The bus is split into four segment lanes. Each lane has its own start-of-packet, end-of-packet, header-valid and data-valid bits, plus a side bit that marks a packet short enough to fit in one segment. A single ready signal is shared by all lanes. The monitor never drives, holds or alters traffic. It only observes the bus and records rule breaks.

A layout input picks how the lanes are grouped. In the quad layout, all four lanes form one wide link. In the dual layout, lanes 0–1 and lanes 2–3 are two independent narrow links, each with its own packet state. In the single-width layout, only lanes 0 and 1 are in use.

On every clock the monitor tests its rules for packet placement, packet continuity and stall timing. Each rule owns one sticky bit in an error vector. These bits clear only on reset, and an aggregate output reports whether any of them is set.

Top module: `tlp_tx_seg_monitor`

## Requirements
- R1: Bit 0 (gap) sets when a packet is open and a lane that should carry its next part is idle while ready is high. An idle lane while ready is low sets nothing and leaves the packet open.
- R2: Bit 2 (start lane) sets in the quad layout (layout=0) when start appears on lane 1 or lane 3. It also sets in the single-width layout when any lane 2 or 3 bit is active.
- R3: Bit 3 (quad lane-2 start) sets when, in the quad layout, lane 2 starts a packet while lanes 0 and 1 are both busy and lane 1 does not carry an end.
- R4: Bit 4 (narrow start) sets in the dual layout (layout=1) when the upper lane of a link (lane 1 or 3) starts a packet and the lower lane holds neither of these: a complete one-lane packet (start, end, header and data all set), or a bare tail (end and data only).
- R5: Bit 1 (order) sets when a lane starts a packet while one is still open on its link. It also sets when a busy lane carries no start while no packet is open. Lanes are walked in ascending index, and a packet wraps from the last lane of its link to lane 0 of that link on the next beat.
- R6: Bit 6 (short) sets when a lane asserts start with the one-segment mark but no end in that same lane.
- R7: Bit 7 (stall) sets on the 17th consecutive cycle in which ready is low and some lane is busy. Up to 16 such cycles set nothing, and an idle cycle restarts the count.
- R8: Bit 5 (single start) sets in the single-width layout (layout=2) in either of two cases. The first is starts on both lanes 0 and 1 in one cycle. The second is a start on lane 1 while lane 0 does not hold data of an earlier packet (data valid with no start).
- R9: Bit 8 (marker) sets when a lane asserts start without header-valid. It also sets when a lane with neither header-valid nor data-valid asserts start or end.
- R10: All error bits read zero after reset. Once set, a bit stays set until reset. The aggregate output is high exactly when any bit is set. A bit reflects a beat on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| layout | input | 2 | 0 quad, 1 dual, 2 single-width |
| tx_ready | input | 1 | Shared ready from the core |
| lane_sop | input | 4 | Per-lane start of packet |
| lane_eop | input | 4 | Per-lane end of packet |
| lane_hval | input | 4 | Per-lane header valid |
| lane_dval | input | 4 | Per-lane data valid |
| lane_short | input | 4 | Per-lane mark: packet fits one segment |
| err_flags | output | 9 | Sticky per-rule error bits |
| err_any | output | 1 | OR of all error bits |

## Verification
The bench plays legal multi-beat traffic in each layout. This includes packets that wrap from the last lane back to lane 0 and a lane-2 start in the quad layout, and it shows that none of the rules fires on correct traffic. Each illegal placement is then driven on its own after a reset, so that every error bit can be traced to one cause. The same lane pattern is exercised under different layouts: a lane-3 start and a lane-2 start while lane 0 is open are both legal in the dual layout but illegal in the quad layout. The stall window is probed at 16 cycles and at 17 cycles, with an idle cycle between the two runs, which separates an off-by-one count from a count that never restarts.

// File: rtl/tlpmon_pkg.sv
// Shared constants for the segmented transmit monitor: lane count,
// layout codes and the position of each rule's error bit.
package tlpmon_pkg;
    localparam int NUM_SEG   = 4;
    localparam int NUM_LINKS = 2;
    localparam int NUM_RULES = 9;

    typedef enum logic [1:0] {
        LAYOUT_QUAD   = 2'd0,
        LAYOUT_DUAL   = 2'd1,
        LAYOUT_SINGLE = 2'd2
    } layout_e;

    localparam int E_GAP    = 0;
    localparam int E_ORDER  = 1;
    localparam int E_START  = 2;
    localparam int E_QSTART = 3;
    localparam int E_NSTART = 4;
    localparam int E_SSTART = 5;
    localparam int E_SHORT  = 6;
    localparam int E_STALL  = 7;
    localparam int E_MARKER = 8;
endpackage

// File: rtl/tlpmon_place_rules.sv
// Combinational placement rules for one beat.
// Checks which lane may start a packet under the selected layout,
// the one-segment end rule and the header/marker consistency rule.
// Assumes the layout input is static between resets; code 3 acts as quad.
module tlpmon_place_rules
    import tlpmon_pkg::*;
(
    input  logic               is_quad,
    input  logic               is_dual,
    input  logic               is_single,
    input  logic [NUM_SEG-1:0] sop,
    input  logic [NUM_SEG-1:0] eop,
    input  logic [NUM_SEG-1:0] hval,
    input  logic [NUM_SEG-1:0] dval,
    input  logic [NUM_SEG-1:0] shortm,
    output logic               start_err,
    output logic               qstart_err,
    output logic               nstart_err,
    output logic               sstart_err,
    output logic               short_err,
    output logic               marker_err
);
    localparam int HALF = NUM_SEG / 2;

    logic [NUM_SEG-1:0] busy;
    logic [NUM_SEG-1:0] whole;
    logic [NUM_SEG-1:0] tail;

    // Per-lane classification of what the lane carries this beat.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_lane
        assign busy[g]  = hval[g] | dval[g];
        assign whole[g] = sop[g] & eop[g] & hval[g] & dval[g];
        assign tail[g]  = eop[g] & ~sop[g] & ~hval[g] & dval[g];
    end

    // Layout-dependent start-position rules.
    always_comb begin
        start_err  = 1'b0;
        qstart_err = 1'b0;
        nstart_err = 1'b0;
        sstart_err = 1'b0;
        if (is_quad) begin
            start_err  = sop[1] | sop[3];
            qstart_err = sop[2] & busy[0] & busy[1] & ~eop[1];
        end
        if (is_dual) begin
            nstart_err = (sop[1] & ~(whole[0] | tail[0]))
                       | (sop[HALF+1] & ~(whole[HALF] | tail[HALF]));
        end
        if (is_single) begin
            start_err  = |(busy[NUM_SEG-1:HALF] | sop[NUM_SEG-1:HALF]
                           | eop[NUM_SEG-1:HALF]);
            sstart_err = (sop[0] & sop[1]) | (sop[1] & ~(dval[0] & ~sop[0]));
        end
    end

    // Layout-independent lane consistency rules.
    always_comb begin
        short_err  = |(sop & shortm & ~eop);
        marker_err = |(sop & ~hval) | |(~busy & (sop | eop));
    end
endmodule

// File: rtl/tlpmon_seq_tracker.sv
// Tracks whether a packet is open on each link and walks the lanes in
// ascending order each beat, flagging gaps and out-of-order starts/ends.
// Assumes: quad uses one link over all lanes, dual splits lanes into two
// links of equal width, single-width uses only the lower half of lanes.
module tlpmon_seq_tracker
    import tlpmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               is_dual,
    input  logic               is_single,
    input  logic               ready,
    input  logic [NUM_SEG-1:0] sop,
    input  logic [NUM_SEG-1:0] eop,
    input  logic [NUM_SEG-1:0] busy,
    output logic               gap_err,
    output logic               order_err
);
    localparam int HALF = NUM_SEG / 2;

    logic [NUM_LINKS-1:0] open_q;
    logic [NUM_LINKS-1:0] open_d;
    logic                 cur;

    // Lane walk: advance the open-packet state through this beat's lanes.
    always_comb begin
        gap_err   = 1'b0;
        order_err = 1'b0;
        open_d    = open_q;
        cur       = open_q[0];
        for (int s = 0; s < NUM_SEG; s++) begin
            if (is_dual && s == HALF) begin
                open_d[0] = cur;
                cur       = open_q[1];
            end
            if (!(is_single && s >= HALF)) begin
                if (busy[s]) begin
                    if (sop[s]) begin
                        if (cur) order_err = 1'b1;
                        cur = ~eop[s];
                    end else if (!cur) begin
                        order_err = 1'b1;
                    end else if (eop[s]) begin
                        cur = 1'b0;
                    end
                end else if (cur && ready) begin
                    gap_err = 1'b1;
                end
            end
        end
        if (is_dual) begin
            open_d[1] = cur;
        end else begin
            open_d[0] = cur;
            open_d[1] = 1'b0;
        end
    end

    // Hold the open-packet state between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    // R5: a link never reports open after a beat that closed it in lane order.
    a_r5_close: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_dual && !is_single && busy[NUM_SEG-1] && eop[NUM_SEG-1]) |=> !open_q[0]);
endmodule

// File: rtl/tlpmon_stall_timer.sv
// Counts consecutive cycles with ready low while any lane is busy and
// reports the first cycle beyond the allowed window.
// Assumes LIMIT is the number of tolerated cycles; the count saturates.
module tlpmon_stall_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic busy,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CLIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          held;

    // Current cycle is a stalled-but-valid cycle.
    assign held = ~ready & busy;
    assign hit  = held & (cnt_q == CLIM);

    // Saturating run-length counter of stalled-valid cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!held)      cnt_q <= '0;
        else if (cnt_q != CLIM) cnt_q <= cnt_q + 1'b1;
    end

    // R7: the run counter restarts after any cycle that is not held.
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !held |=> (cnt_q == '0));
endmodule

// File: rtl/tlp_tx_seg_monitor.sv
// Top of the segmented transmit protocol monitor. Decodes the layout,
// combines the rule modules and keeps one sticky bit per rule.
// Assumes a passive tap: no output influences the bus.
module tlp_tx_seg_monitor
    import tlpmon_pkg::*;
#(
    parameter int STALL_LIMIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           layout,
    input  logic                 tx_ready,
    input  logic [NUM_SEG-1:0]   lane_sop,
    input  logic [NUM_SEG-1:0]   lane_eop,
    input  logic [NUM_SEG-1:0]   lane_hval,
    input  logic [NUM_SEG-1:0]   lane_dval,
    input  logic [NUM_SEG-1:0]   lane_short,
    output logic [NUM_RULES-1:0] err_flags,
    output logic                 err_any
);
    logic                 is_quad, is_dual, is_single;
    logic [NUM_SEG-1:0]   busy;
    logic [NUM_RULES-1:0] beat_err;
    logic [NUM_RULES-1:0] err_q;
    logic                 gap_e, order_e, start_e, qstart_e, nstart_e;
    logic                 sstart_e, short_e, stall_e, marker_e;

    // Layout decode; unused code 3 falls back to quad.
    always_comb begin
        is_dual   = (layout == LAYOUT_DUAL);
        is_single = (layout == LAYOUT_SINGLE);
        is_quad   = ~is_dual & ~is_single;
    end

    assign busy = lane_hval | lane_dval;

    tlpmon_place_rules u_place (
        .is_quad    (is_quad),
        .is_dual    (is_dual),
        .is_single  (is_single),
        .sop        (lane_sop),
        .eop        (lane_eop),
        .hval       (lane_hval),
        .dval       (lane_dval),
        .shortm     (lane_short),
        .start_err  (start_e),
        .qstart_err (qstart_e),
        .nstart_err (nstart_e),
        .sstart_err (sstart_e),
        .short_err  (short_e),
        .marker_err (marker_e)
    );

    tlpmon_seq_tracker u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_dual   (is_dual),
        .is_single (is_single),
        .ready     (tx_ready),
        .sop       (lane_sop),
        .eop       (lane_eop),
        .busy      (busy),
        .gap_err   (gap_e),
        .order_err (order_e)
    );

    tlpmon_stall_timer #(.LIMIT(STALL_LIMIT)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (tx_ready),
        .busy  (|busy),
        .hit   (stall_e)
    );

    // Gather this beat's rule results into bit positions.
    always_comb begin
        beat_err           = '0;
        beat_err[E_GAP]    = gap_e;
        beat_err[E_ORDER]  = order_e;
        beat_err[E_START]  = start_e;
        beat_err[E_QSTART] = qstart_e;
        beat_err[E_NSTART] = nstart_e;
        beat_err[E_SSTART] = sstart_e;
        beat_err[E_SHORT]  = short_e;
        beat_err[E_STALL]  = stall_e;
        beat_err[E_MARKER] = marker_e;
    end

    // Sticky error capture, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_q | beat_err;
    end

    assign err_flags = err_q;
    assign err_any   = |err_q;

    // R10: a set bit never clears without reset.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_q & $past(err_q)) == $past(err_q)));
    // R2: odd-lane start in quad layout is recorded on the next edge.
    a_r2_odd_start: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == 2'd0 && (lane_sop[1] || lane_sop[3])) |=> err_q[E_START]);
    // R6: short packet without same-lane end is recorded.
    a_r6_short: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lane_sop & lane_short & ~lane_eop)) |=> err_q[E_SHORT]);
    // R9: start without header valid is recorded.
    a_r9_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lane_sop & ~lane_hval)) |=> err_q[E_MARKER]);
    // R7: the stall timer's report reaches the sticky bit.
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall_e |=> err_q[E_STALL]);
endmodule

// File: tb/tlp_tx_seg_monitor_tb_top.sv
`timescale 1ns/1ps
module tlp_tx_seg_monitor_tb_top;
    localparam int NS = 4;
    localparam int NR = 9;
    // Bit positions per the requirements.
    localparam int B_GAP = 0, B_ORD = 1, B_ST = 2, B_QS = 3, B_NS = 4;
    localparam int B_SS = 5, B_SH = 6, B_STL = 7, B_MK = 8;

    typedef struct {
        logic [NR:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    layout = 2'd0;
    logic          rdy = 1'b1;
    logic [NS-1:0] sop = '0, eop = '0, hv = '0, dv = '0, sh = '0;
    logic [NR-1:0] err_flags;
    logic          err_any;

    item_t       sbq[$];
    logic [NR-1:0] acc = '0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    tlp_tx_seg_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .layout(layout), .tx_ready(rdy),
        .lane_sop(sop), .lane_eop(eop), .lane_hval(hv), .lane_dval(dv),
        .lane_short(sh), .err_flags(err_flags), .err_any(err_any)
    );

    // Monitor: compare each expected item just after the edge that samples its beat.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_cmp++;
            if ({err_any, err_flags} !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%b expected=%b", it.tag, {err_any, err_flags}, it.exp);
            end
        end
    end

    // Driver: present one beat and push the expected flag state.
    task automatic beat(input logic [NS-1:0] s, e, h, d, m, input logic r,
                        input logic [NR-1:0] add, input string tag);
        item_t it;
        @(negedge clk);
        sop = s; eop = e; hv = h; dv = d; sh = m; rdy = r;
        acc = acc | add;
        it.exp = {|acc, acc};
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Reset under a given layout and check the cleared state (R10).
    task automatic do_reset(input logic [1:0] lay);
        @(negedge clk);
        rst_n = 1'b0; layout = lay;
        sop = '0; eop = '0; hv = '0; dv = '0; sh = '0; rdy = 1'b1;
        acc = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n_cmp++;
        if ({err_any, err_flags} !== '0) begin
            n_bad++;
            $display("FAIL R10 reset: actual=%b expected=%b", {err_any, err_flags}, {(NR+1){1'b0}});
        end
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // Quad legal traffic with wrap and lane-2 starts (R3, R5).
        do_reset(2'd0);
        beat(4'b0001, 4'b0000, 4'b0001, 4'b1111, 4'b0000, 1, '0, "R5 quad open");
        beat(4'b0100, 4'b0101, 4'b0100, 4'b0101, 4'b0100, 1, '0, "R3 quad lane2 legal");
        beat(4'b0101, 4'b0001, 4'b0101, 4'b1101, 4'b0001, 1, '0, "R5 quad wrap open");
        beat(4'b0000, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 1, '0, "R5 quad wrap close");
        beat(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, '0, "R10 idle holds zero");
        // Odd-lane start in quad (R2).
        beat(4'b0011, 4'b0011, 4'b0011, 4'b0011, 4'b0011, 1, 9'(1 << B_ST), "R2 lane1 start");
        beat(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, '0, "R10 sticky start");
        drain();

        // Lane-2 start while lane1 continues (R3 plus R5 nested start).
        do_reset(2'd0);
        beat(4'b0101, 4'b0100, 4'b0101, 4'b0111, 4'b0100, 1,
             9'((1 << B_QS) | (1 << B_ORD)), "R3 lane2 blocked");
        drain();

        // Gap allowed under ready low, flagged under ready high (R1).
        do_reset(2'd0);
        beat(4'b0001, 4'b0000, 4'b0001, 4'b1111, 4'b0000, 1, '0, "R1 open");
        beat(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, '0, "R1 pause ok");
        beat(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 9'(1 << B_GAP), "R1 gap");
        drain();

        // Orphan tail with no open packet (R5).
        do_reset(2'd0);
        beat(4'b0000, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 1, 9'(1 << B_ORD), "R5 orphan");
        drain();

        // Dual layout legal traffic, independent links (R4, R5).
        do_reset(2'd1);
        beat(4'b0111, 4'b0011, 4'b0111, 4'b1111, 4'b0011, 1, '0, "R4 dual whole then start");
        beat(4'b1001, 4'b1100, 4'b1001, 4'b1111, 4'b1000, 1, '0, "R4 dual tail then start");
        beat(4'b0100, 4'b0101, 4'b0100, 4'b0101, 4'b0100, 1, '0, "R5 dual close");
        beat(4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 1, 9'(1 << B_NS), "R4 upper start idle lower");
        drain();

        // Single-width: legal continuation then double start (R8), upper lanes (R2).
        do_reset(2'd2);
        beat(4'b0001, 4'b0000, 4'b0001, 4'b0011, 4'b0000, 1, '0, "R8 single open");
        beat(4'b0010, 4'b0011, 4'b0010, 4'b0011, 4'b0010, 1, '0, "R8 lane1 after data");
        beat(4'b0011, 4'b0011, 4'b0011, 4'b0011, 4'b0011, 1, 9'(1 << B_SS), "R8 two starts");
        beat(4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b0100, 1, 9'(1 << B_ST), "R2 single upper lane");
        drain();
        do_reset(2'd2);
        beat(4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 1, 9'(1 << B_SS), "R8 lane1 idle lane0");
        drain();

        // Short packet without same-lane end (R6).
        do_reset(2'd0);
        beat(4'b0001, 4'b0010, 4'b0001, 4'b0011, 4'b0001, 1, 9'(1 << B_SH), "R6 short spans");
        drain();

        // Marker rules (R9).
        do_reset(2'd0);
        beat(4'b0001, 4'b0001, 4'b0000, 4'b0001, 4'b0001, 1, 9'(1 << B_MK), "R9 start no header");
        drain();
        do_reset(2'd0);
        beat(4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 1, 9'(1 << B_MK), "R9 bare end");
        drain();

        // Stall window: 16 held, idle restart, 16 held, 17th flags (R7).
        do_reset(2'd0);
        beat(4'b0001, 4'b0000, 4'b0001, 4'b1111, 4'b0000, 0, '0, "R7 held 1");
        for (int i = 2; i <= 16; i++)
            beat(4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 0, '0, "R7 held within window");
        beat(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, '0, "R7 idle restart");
        for (int i = 1; i <= 16; i++)
            beat(4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 0, '0, "R7 held second run");
        beat(4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 0, 9'(1 << B_STL), "R7 17th cycle");
        drain();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule